// File: doc/BRIEF.md
# Vector Load/Store Element Address Generator

This block forms one effective address per element for a vectorised load/store pipeline. Each valid cycle it receives the base register value for the element, a signed displacement, the element-stride control bit, a flag telling whether the address register is itself a vector, the sub-vector length and the element and sub-element step counters for both the source and the destination sides. From these it forms an offset multiplier and picks one of four addressing kinds. One cycle later it presents the wrapped 64-bit address, the chosen kind and a valid strobe.

Loads count with the source steps. Loads can also take a remapped step straight from outside. Stores always count with the destination steps and never use remapped stepping. A zero displacement with element striding requested turns striding off. Every element then targets the same location, which serves repeated reads of a cache-inhibited address.

Top module: `vls_addr_gen`

## Requirements
- R1: For a load with `remap_en` low, the offset multiplier is `src_step * (subvl + 1) + src_sub`.
- R2: For a store, the offset multiplier is `dst_step * (subvl + 1) + dst_sub`. The source steps have no effect.
- R3: For a load with `remap_en` high, the offset multiplier equals `remap_step`.
- R4: A store ignores `remap_en` and `remap_step`. Its address is the same as with remapping off.
- R5: Unit-strided address = `base + imm + mult * bytes`. `len_code` 0, 1, 2, 3 selects 1, 2, 4, 8 bytes.
- R6: When `ra_vec` is high the kind is indexed (`out_kind` = 0) whatever the other inputs are, and the address is `base + imm`.
- R7: When `ra_vec` is low and `elstride` is clear, the kind is unit-strided (`out_kind` = 1).
- R8: When `ra_vec` is low, `elstride` is set and `imm` is zero, the kind is fixed (`out_kind` = 3). The address is `base` for every step value.
- R9: When `ra_vec` is low, `elstride` is set and `imm` is non-zero, the kind is element-strided (`out_kind` = 2). The address is `base + imm * mult`.
- R10: `out_valid` is high exactly one cycle after `in_valid` was high. It is low after reset, and after reset `out_addr` is zero.
- R11: All address sums and products wrap modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Element request valid |
| is_store | input | 1 | 1 = store, 0 = load |
| remap_en | input | 1 | Loads take the multiplier from `remap_step` |
| remap_step | input | 11 | Remapped offset multiplier |
| base | input | 64 | Base (or per-element index) register value |
| imm | input | 64 | Sign-extended displacement |
| elstride | input | 1 | Element-stride request bit |
| ra_vec | input | 1 | Address register is a vector |
| subvl | input | 2 | Sub-vector length minus one |
| src_step | input | 8 | Source element step |
| src_sub | input | 2 | Source sub-element step |
| dst_step | input | 8 | Destination element step |
| dst_sub | input | 2 | Destination sub-element step |
| len_code | input | 2 | Data length: 1 << len_code bytes |
| out_valid | output | 1 | Address valid |
| out_addr | output | 64 | Effective address |
| out_kind | output | 2 | 0 indexed, 1 unit, 2 element-strided, 3 fixed |

## Verification
The assertions assume that reset is applied with `in_valid` low. They also assume that inputs change only between clock edges, so `$past` of the request fields at a valid cycle is the element that was captured. The stimulus holds `in_valid` low for the whole reset and drives every field on the falling edge.

Sub-element steps are kept below `subvl + 1` so that the multipliers are meaningful. The wrap cases are still reached on purpose, through large bases and negative displacements. Idle gaps are placed between bursts to show that no address appears without a request.

// File: rtl/vls_addr_pkg.sv
package vls_addr_pkg;
   typedef enum logic [1:0] {
      KIND_INDEXED = 2'd0,
      KIND_UNIT    = 2'd1,
      KIND_ELEM    = 2'd2,
      KIND_FIXED   = 2'd3
   } acc_kind_e;
endpackage

// File: rtl/vls_offs_mul.sv
module vls_offs_mul #(
   parameter int STEP_W    = 8,
   parameter int SUB_W     = 2,
   parameter bit HAS_REMAP = 1'b1,
   localparam int OFF_W    = STEP_W + SUB_W + 1
) (
   input  logic              is_store,
   input  logic              remap_en,
   input  logic [OFF_W-1:0]  remap_step,
   input  logic [SUB_W-1:0]  subvl,
   input  logic [STEP_W-1:0] src_step,
   input  logic [SUB_W-1:0]  src_sub,
   input  logic [STEP_W-1:0] dst_step,
   input  logic [SUB_W-1:0]  dst_sub,
   output logic [OFF_W-1:0]  mult
);
   logic [OFF_W-1:0] sv_len;
   logic [OFF_W-1:0] src_lin;
   logic [OFF_W-1:0] dst_lin;

   always_comb begin
      sv_len  = OFF_W'(subvl) + OFF_W'(1);
      src_lin = OFF_W'(src_step) * sv_len + OFF_W'(src_sub);
      dst_lin = OFF_W'(dst_step) * sv_len + OFF_W'(dst_sub);
   end

   generate
      if (HAS_REMAP) begin : g_remap
         // stores never follow the remapped order
         always_comb mult = is_store ? dst_lin : (remap_en ? remap_step : src_lin);
      end else begin : g_linear
         logic unused_remap;
         always_comb unused_remap = remap_en ^ (^remap_step);
         always_comb mult = is_store ? dst_lin : src_lin;
      end
   endgenerate
endmodule

// File: rtl/vls_kind_sel.sv
module vls_kind_sel
   import vls_addr_pkg::*;
#(
   parameter int AW = 64
) (
   input  logic          ra_vec,
   input  logic          elstride,
   input  logic [AW-1:0] imm,
   output acc_kind_e     kind
);
   always_comb begin
      if (ra_vec)          kind = KIND_INDEXED;
      else if (!elstride)  kind = KIND_UNIT;
      else if (imm == '0)  kind = KIND_FIXED;
      else                 kind = KIND_ELEM;
   end
endmodule

// File: rtl/vls_addr_calc.sv
module vls_addr_calc
   import vls_addr_pkg::*;
#(
   parameter int AW    = 64,
   parameter int OFF_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [AW-1:0]    base,
   input  logic [AW-1:0]    imm,
   input  logic [OFF_W-1:0] mult,
   input  logic [1:0]       len_code,
   input  acc_kind_e        kind,
   output logic             out_valid,
   output logic [AW-1:0]    out_addr,
   output acc_kind_e        out_kind
);
   logic [AW-1:0] mult_x;
   logic [AW-1:0] unit_off;
   logic [AW-1:0] next_addr;

   always_comb begin
      mult_x   = AW'(mult);
      unit_off = mult_x << len_code;
      unique case (kind)
         KIND_INDEXED: next_addr = base + imm;
         KIND_UNIT:    next_addr = base + imm + unit_off;
         KIND_ELEM:    next_addr = base + imm * mult_x;
         default:      next_addr = base;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_addr  <= '0;
         out_kind  <= KIND_INDEXED;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_addr <= next_addr;
            out_kind <= kind;
         end
      end
   end

   p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_fixed_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && kind == KIND_FIXED) |=> (out_addr == $past(base)));
endmodule

// File: rtl/vls_addr_gen.sv
module vls_addr_gen
   import vls_addr_pkg::*;
#(
   parameter int AW        = 64,
   parameter int STEP_W    = 8,
   parameter int SUB_W     = 2,
   parameter bit HAS_REMAP = 1'b1,
   localparam int OFF_W    = STEP_W + SUB_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              is_store,
   input  logic              remap_en,
   input  logic [OFF_W-1:0]  remap_step,
   input  logic [AW-1:0]     base,
   input  logic [AW-1:0]     imm,
   input  logic              elstride,
   input  logic              ra_vec,
   input  logic [SUB_W-1:0]  subvl,
   input  logic [STEP_W-1:0] src_step,
   input  logic [SUB_W-1:0]  src_sub,
   input  logic [STEP_W-1:0] dst_step,
   input  logic [SUB_W-1:0]  dst_sub,
   input  logic [1:0]        len_code,
   output logic              out_valid,
   output logic [AW-1:0]     out_addr,
   output logic [1:0]        out_kind
);
   generate
      if (AW < 16) begin : g_bad_aw
         $error("vls_addr_gen: AW must be at least 16");
      end
      if (OFF_W + 3 > AW) begin : g_bad_off
         $error("vls_addr_gen: shifted multiplier does not fit AW");
      end
      if (SUB_W < 1) begin : g_bad_sub
         $error("vls_addr_gen: SUB_W must be at least 1");
      end
   endgenerate

   logic [OFF_W-1:0] mult;
   acc_kind_e        kind;
   acc_kind_e        kind_q;

   vls_offs_mul #(.STEP_W(STEP_W), .SUB_W(SUB_W), .HAS_REMAP(HAS_REMAP)) offs_i (
      .is_store(is_store), .remap_en(remap_en), .remap_step(remap_step),
      .subvl(subvl), .src_step(src_step), .src_sub(src_sub),
      .dst_step(dst_step), .dst_sub(dst_sub), .mult(mult)
   );

   vls_kind_sel #(.AW(AW)) kind_i (
      .ra_vec(ra_vec), .elstride(elstride), .imm(imm), .kind(kind)
   );

   vls_addr_calc #(.AW(AW), .OFF_W(OFF_W)) calc_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base(base), .imm(imm),
      .mult(mult), .len_code(len_code), .kind(kind),
      .out_valid(out_valid), .out_addr(out_addr), .out_kind(kind_q)
   );

   assign out_kind = kind_q;

   p_indexed_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ra_vec) |=> (out_kind == KIND_INDEXED));
   p_unit_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !ra_vec && !elstride) |=> (out_kind == KIND_UNIT));
   p_indexed_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ra_vec) |=> (out_addr == $past(base) + $past(imm)));
endmodule

// File: tb/vls_addr_gen_tb_top.sv
module vls_addr_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        is_store = 1'b0;
   logic        remap_en = 1'b0;
   logic [10:0] remap_step = '0;
   logic [63:0] base = '0;
   logic [63:0] imm = '0;
   logic        elstride = 1'b0;
   logic        ra_vec = 1'b0;
   logic [1:0]  subvl = '0;
   logic [7:0]  src_step = '0;
   logic [1:0]  src_sub = '0;
   logic [7:0]  dst_step = '0;
   logic [1:0]  dst_sub = '0;
   logic [1:0]  len_code = '0;
   logic        out_valid;
   logic [63:0] out_addr;
   logic [1:0]  out_kind;

   int checks = 0;
   int errors = 0;

   logic [65:0] exp_q[$];
   string       tag_q[$];

   always #10 clk = ~clk;

   vls_addr_gen dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_store(is_store),
      .remap_en(remap_en), .remap_step(remap_step), .base(base), .imm(imm),
      .elstride(elstride), .ra_vec(ra_vec), .subvl(subvl),
      .src_step(src_step), .src_sub(src_sub), .dst_step(dst_step),
      .dst_sub(dst_sub), .len_code(len_code),
      .out_valid(out_valid), .out_addr(out_addr), .out_kind(out_kind)
   );

   task automatic check(input string req, input logic [65:0] act, input logic [65:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // model written from the requirements
   function automatic logic [65:0] model();
      logic [63:0] m;
      logic [63:0] bytes;
      if (is_store)      m = 64'(dst_step) * (64'(subvl) + 1) + 64'(dst_sub);
      else if (remap_en) m = 64'(remap_step);
      else               m = 64'(src_step) * (64'(subvl) + 1) + 64'(src_sub);
      bytes = 64'd1 << len_code;
      if (ra_vec)          return {2'd0, base + imm};
      else if (!elstride)  return {2'd1, base + imm + m * bytes};
      else if (imm == 0)   return {2'd3, base};
      else                 return {2'd2, base + imm * m};
   endfunction

   task automatic issue(input string req);
      in_valid = 1'b1;
      exp_q.push_back(model());
      tag_q.push_back(req);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            check("R10 unexpected valid", 66'd1, 66'd0);
         end else begin
            logic [65:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {out_kind, out_addr}, e);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      check("watchdog", 66'd1, 66'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R10 reset valid", 66'(out_valid), 66'd0);
      check("R10 reset addr", 66'(out_addr), 66'd0);
      @(negedge clk);

      // R1 R5 R7: load, unit stride, 4-byte elements
      base = 64'h1000; imm = 64'h10; subvl = 2'd1; src_step = 8'd3; src_sub = 2'd1;
      dst_step = 8'd9; dst_sub = 2'd0; len_code = 2'd2;
      issue("R1 R5 R7 load unit");
      // R2: store uses destination steps
      is_store = 1'b1; subvl = 2'd0; dst_step = 8'd2; len_code = 2'd3;
      issue("R2 store unit");
      // R4: store ignores remapping
      remap_en = 1'b1; remap_step = 11'd77;
      issue("R4 store remap ignored");
      // R3: load takes remapped step
      is_store = 1'b0; remap_step = 11'd5; len_code = 2'd0;
      issue("R3 load remap");
      remap_en = 1'b0;
      // R5: every length code
      subvl = 2'd3; src_step = 8'd4; src_sub = 2'd2;
      for (int c = 0; c < 4; c++) begin
         len_code = 2'(c);
         issue("R5 length code");
      end
      @(negedge clk);
      check("R10 idle no valid", 66'(out_valid), 66'd0);

      // R6: indexed wins even with stride and zero imm
      ra_vec = 1'b1; elstride = 1'b1; imm = 64'h0; base = 64'hABCD_0000;
      issue("R6 indexed priority");
      imm = 64'h40; elstride = 1'b0;
      issue("R6 indexed addr");
      ra_vec = 1'b0;
      // R9: element strided
      elstride = 1'b1; imm = 64'h20; subvl = 2'd0; src_step = 8'd4; src_sub = 2'd0;
      issue("R9 element strided");
      // R11: negative displacement wraps
      imm = 64'hFFFF_FFFF_FFFF_FFF8; base = 64'h100; src_step = 8'd6;
      issue("R9 R11 negative stride");
      // R8: zero displacement freezes the address
      imm = 64'h0; base = 64'h8000_0040;
      for (int s = 0; s < 3; s++) begin
         src_step = 8'(s * 7 + 1);
         issue("R8 fixed location");
      end
      // R11: unit stride wrap around
      elstride = 1'b0; base = 64'hFFFF_FFFF_FFFF_FFF0; imm = 64'h20;
      src_step = 8'd255; subvl = 2'd3; src_sub = 2'd3; len_code = 2'd3;
      issue("R11 unit wrap");
      // R2: store source steps have no effect
      is_store = 1'b1; dst_step = 8'd1; dst_sub = 2'd1; src_step = 8'd200;
      issue("R2 store src ignored");
      is_store = 1'b0;

      repeat (3) @(negedge clk);
      check("R10 all results seen", 66'(exp_q.size()), 66'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule